// File: doc/BRIEF.md
# Delay-Aligning Bit-Serial Adder

This block adds two unsigned words that arrive one bit per clock, least significant bit first. Each operand comes from an upstream chain whose latency is known when the design is elaborated. That latency is given to the block as a parameter. The block pads the operand with less latency using register stages, so that bits of the same weight meet at the adder in the same cycle. It then adds them with a single registered full adder and a carry flip-flop.

Word timing comes from a one-hot sync bus that is shared across the datapath. Line j of the bus is high in the cycle where a stream with zero latency carries bit j. A stream with latency D therefore carries its bit 0 while line D mod n is high. The adder selects the line that matches its aligned latency and uses it to clear the carry at each word start. The result leaves with latency max(DLY_A, DLY_B) + 1, and this value is also driven on a constant output port. The stream is a fixed-latency pipeline with one bit in every cycle. It has no valid/ready handshake, so back-pressure cannot be applied and downstream logic must accept one bit per clock.

Top module: `bitser_align_add`

## Requirements
- R1: `sum_bit` carries the word (A + B) mod 2^WORD_W, LSB first, one bit per clock, with no gaps between words.
- R2: Line j of `sync_bus` is high only in the cycle where a zero-latency stream carries bit j. A stream of latency D presents bit 0 while line D mod WORD_W is high. At most one line is high in any cycle.
- R3: The operand with less latency is delayed by |DLY_A − DLY_B| register stages, so that bits of equal weight are added together.
- R4: Bit j of word w appears on `sum_bit` in cycle max(DLY_A, DLY_B) + 1 + w·WORD_W + j, counted from the cycle in which line 0 is first high. Before that cycle, `sum_bit` stays 0.
- R5: The carry is cleared at the start of every word. A carry out of the MSB has no effect on the next word.
- R6: `out_latency` equals max(DLY_A, DLY_B) + 1.
- R7: While `rst_n` is low, `sum_bit` is 0, whatever the inputs are.
- R8: Latencies larger than WORD_W work correctly, with the selected line wrapping modulo WORD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_bus | input | WORD_W | One-hot word-position strobes |
| a_bit | input | 1 | Serial operand A, latency DLY_A |
| b_bit | input | 1 | Serial operand B, latency DLY_B |
| sum_bit | output | 1 | Serial sum, latency max(DLY_A, DLY_B) + 1 |
| out_latency | output | LAT_W | Constant output latency in clocks |

## Verification
Two instances run side by side. One has B with more latency than A. The other has A with more latency, and its latency exceeds the word width, so the sync line has to wrap. A design that padded the wrong operand or picked an unwrapped line would produce shifted or mixed words. Directed words 0xFFFF+0x0001 and 0xFFFF+0xFFFF exercise the full carry ripple. The sequence 0x8000+0x8000 followed by 0+0 catches a carry that leaks across a word boundary, which would show up as a stray 1 in the next word's bit 0. The bench also watches the output before the stated latency and during a reset with toggling inputs. Any early or off-by-one bit there is reported.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/bsa_delay.sv
module bsa_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH:0] tap;
  assign tap[0] = din;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[i+1] <= 1'b0;
      else        tap[i+1] <= tap[i];
    end
  end

  assign dout = tap[DEPTH];
endmodule

// File: rtl/bsa_sync_pick.sv
module bsa_sync_pick #(
  parameter int WORD_W = 16,
  parameter int LINE   = 0
) (
  input  logic [WORD_W-1:0] sync_bus,
  output logic              start
);
  localparam logic [WORD_W-1:0] MASK = WORD_W'(1) << LINE;
  assign start = |(sync_bus & MASK);
endmodule

// File: rtl/bsa_add_core.sv
module bsa_add_core (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic a,
  input  logic b,
  output logic sum,
  output logic carry
);
  logic cin;
  assign cin = start ? 1'b0 : carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= 1'b0;
      carry <= 1'b0;
    end else begin
      sum   <= a ^ b ^ cin;
      carry <= (a & b) | (a & cin) | (b & cin);
    end
  end
endmodule

// File: rtl/bitser_align_add.sv
module bitser_align_add
  import bsa_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DLY_A  = 2,
  parameter int DLY_B  = 5,
  parameter int LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sync_bus,
  input  logic              a_bit,
  input  logic              b_bit,
  output logic              sum_bit,
  output logic [LAT_W-1:0]  out_latency
);
  localparam int DMAX     = imax(DLY_A, DLY_B);
  localparam int PAD_A    = DMAX - DLY_A;
  localparam int PAD_B    = DMAX - DLY_B;
  localparam int SYNC_IDX = DMAX % WORD_W;
  localparam int OUT_DLY  = DMAX + 1;

  logic a_al, b_al, start_w, carry_w;

  if (PAD_A > 0) begin : g_pad_a
    bsa_delay #(.DEPTH(PAD_A)) u_pad_a (
      .clk(clk), .rst_n(rst_n), .din(a_bit), .dout(a_al));
  end else begin : g_thru_a
    assign a_al = a_bit;
  end

  if (PAD_B > 0) begin : g_pad_b
    bsa_delay #(.DEPTH(PAD_B)) u_pad_b (
      .clk(clk), .rst_n(rst_n), .din(b_bit), .dout(b_al));
  end else begin : g_thru_b
    assign b_al = b_bit;
  end

  bsa_sync_pick #(.WORD_W(WORD_W), .LINE(SYNC_IDX)) u_pick (
    .sync_bus(sync_bus), .start(start_w));

  bsa_add_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start_w),
    .a(a_al), .b(b_al), .sum(sum_bit), .carry(carry_w));

  assign out_latency = LAT_W'(OUT_DLY);
endmodule

// File: rtl/bitser_align_add_chk.sv
module bitser_align_add_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] sync_bus,
  input logic              start,
  input logic              a_al,
  input logic              b_al,
  input logic              carry,
  input logic              sum_bit
);
  // R2: at most one word-position strobe per cycle
  assert_sync_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_bus));

  // R1: mid-word sum bit uses the carried-in value
  assert_sum_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> sum_bit == $past(a_al ^ b_al ^ carry));

  // R5: first bit of a word ignores the old carry
  assert_sum_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sum_bit == $past(a_al ^ b_al));

  // R5: carry after a word start comes only from the new bits
  assert_carry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> carry == $past(a_al & b_al));

  if (WORD_W > 1) begin : g_gap
    // R2: the selected strobe never holds for two cycles
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
  end
endmodule

bind bitser_align_add bitser_align_add_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_bus(sync_bus), .start(start_w),
  .a_al(a_al), .b_al(b_al), .carry(carry_w), .sum_bit(sum_bit));

// File: tb/test_bitser_align_add.sv
`timescale 1ns/1ps
module test_bitser_align_add;
  localparam int W    = 16;
  localparam int NW   = 40;
  localparam int DA0  = 3,  DB0 = 9;
  localparam int DA1  = 21, DB1 = 4;
  localparam int OUT0 = 10, OUT1 = 22;
  localparam int TOTAL = OUT1 + NW * W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [W-1:0] sync_bus = '0;
  logic a0 = 1'b0, b0 = 1'b0, a1 = 1'b0, b1 = 1'b0;
  logic s0, s1;
  logic [7:0] lat0, lat1;

  always #10 clk = ~clk;

  bitser_align_add #(.WORD_W(W), .DLY_A(DA0), .DLY_B(DB0), .LAT_W(8)) i_bitser_align_add (
    .clk(clk), .rst_n(rst_n), .sync_bus(sync_bus), .a_bit(a0), .b_bit(b0),
    .sum_bit(s0), .out_latency(lat0));

  bitser_align_add #(.WORD_W(W), .DLY_A(DA1), .DLY_B(DB1), .LAT_W(8)) i_bitser_align_add_far (
    .clk(clk), .rst_n(rst_n), .sync_bus(sync_bus), .a_bit(a1), .b_bit(b1),
    .sum_bit(s1), .out_latency(lat1));

  logic [W-1:0] wa [NW];
  logic [W-1:0] wb [NW];
  logic [W-1:0] acc [2];
  int  outd [2] = '{OUT0, OUT1};
  bit  early_bad [2] = '{1'b0, 1'b0};
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic pick(input bit use_b, input int d, input int c);
    int rel, w;
    rel = c - d;
    if (rel < 0) return 1'b0;
    w = rel / W;
    if (w >= NW) return 1'b0;
    return use_b ? wb[w][rel % W] : wa[w][rel % W];
  endfunction

  task automatic observe(input int k, input int c, input logic s);
    int idx, w, j;
    logic [W-1:0] exp;
    string tag;
    if (c < outd[k]) begin
      if (s !== 1'b0) early_bad[k] = 1'b1;
      if (c == outd[k] - 1)
        check(!early_bad[k], "R4", $sformatf("inst%0d quiet before latency", k),
              int'(early_bad[k]), 0);
      return;
    end
    idx = c - outd[k];
    w = idx / W;
    j = idx % W;
    acc[k][j] = s;
    if (j == W - 1 && w < NW) begin
      exp = wa[w] + wb[w];
      if (w == 3)      tag = "R5";
      else if (k == 1) tag = "R8";
      else             tag = "R1 R2 R3";
      check(acc[k] === exp, tag, $sformatf("inst%0d word %0d sum", k, w),
            int'(acc[k]), int'(exp));
    end
  endtask

  initial begin
    bit rbad;
    void'($urandom(32'd4242));
    wa[0] = 16'hFFFF; wb[0] = 16'h0001;
    wa[1] = 16'hFFFF; wb[1] = 16'hFFFF;
    wa[2] = 16'h8000; wb[2] = 16'h8000;
    wa[3] = 16'h0000; wb[3] = 16'h0000;
    wa[4] = 16'hAAAA; wb[4] = 16'h5555;
    for (int i = 5; i < NW; i++) begin
      wa[i] = W'($urandom);
      wb[i] = W'($urandom);
    end

    #1 rst_n = 1'b0;
    rbad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (s0 !== 1'b0 || s1 !== 1'b0) rbad = 1'b1;
      a0 = 1'($urandom); b0 = 1'($urandom);
      a1 = 1'($urandom); b1 = 1'($urandom);
      sync_bus = '0;
      sync_bus[$urandom % W] = 1'b1;
    end
    @(negedge clk);
    if (s0 !== 1'b0 || s1 !== 1'b0) rbad = 1'b1;
    check(!rbad, "R7", "sum held low in reset", int'(rbad), 0);
    check(lat0 == 8'(OUT0), "R6", "inst0 out_latency", int'(lat0), OUT0);
    check(lat1 == 8'(OUT1), "R6", "inst1 out_latency", int'(lat1), OUT1);

    for (int c = 0; c < TOTAL; c++) begin
      if (c > 0) @(negedge clk);
      else rst_n = 1'b1;
      observe(0, c, s0);
      observe(1, c, s1);
      sync_bus = '0;
      sync_bus[c % W] = 1'b1;
      a0 = pick(1'b0, DA0, c);
      b0 = pick(1'b1, DB0, c);
      a1 = pick(1'b0, DA1, c);
      b1 = pick(1'b1, DB1, c);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule